// File: doc/BRIEF.md
# Double-Buffered Four-Channel DAC Register Slave

This block sits on an asynchronous parallel host bus as a memory-mapped slave. It presents four 12-bit channel data words and one transfer-control word to the host. Each channel has two registers: a holding register that the host writes, and an output register that drives a digital-to-analog converter. The transfer-control word sets when the holding values move into the output registers.

Host software sets transfer control to 1, then writes the four channel codes, then clears transfer control to 0. On that 1-to-0 change, all four holding values move into the output registers in the same clock cycle, and the block pulses a load strobe. All four analog outputs therefore change at the same moment. When transfer control is 0, a channel write goes to that channel's output at once. The active-low bus strobes are resynchronised by two-flop chains before use.

Top module: `quad_dac_regs`

## Requirements
- R1: After synchronous reset, all holding and output codes are 0, transfer control is 0, the load strobe is low, and reads of every register return 0.
- R2: Word addresses 0x4100, 0x4102, 0x4104 and 0x4106 select channels A, B, C and D. A read of a channel address returns that channel's holding code in bits 11:0, with bits 15:12 as zero.
- R3: Bits 15:12 of a channel write have no effect. Only bits 11:0 are stored as the unsigned code, from 0 to 4095.
- R4: Address 0x47FF is the transfer-control register. A write stores bit 0 of the data as the control value. A read returns the control value in bit 0, with all other bits zero.
- R5: While transfer control is 1, a channel write changes only that channel's holding code. The output codes hold their values and no load strobe is produced.
- R6: A write that changes transfer control from 1 to 0 copies all four holding codes to the outputs at one clock edge. The load strobe is high for exactly that one cycle.
- R7: While transfer control is 0, a channel write updates both the holding code and the output code of that channel, and pulses the load strobe for one cycle.
- R8: A control write that leaves the value unchanged (0 to 0, or 1 to 1) changes no output code and produces no load strobe.
- R9: A write to any address other than the five decoded ones changes no state. A read of such an address returns 0.
- R10: A write takes effect once per rising edge of the synchronized write strobe, and only while the synchronized chip select is active (low). A write strobe given while chip select is inactive has no effect.
- R11: Read data is 0 whenever the synchronized read strobe and chip select are not both active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs_n | input | 1 | Asynchronous chip select, active low |
| bus_wr_n | input | 1 | Asynchronous write strobe, active low |
| bus_rd_n | input | 1 | Asynchronous read strobe, active low |
| bus_addr | input | 16 | Word address, held stable around the strobes |
| bus_wdata | input | 16 | Write data word |
| bus_rdata | output | 16 | Registered read data |
| dac_code_a | output | 12 | Output code, channel A |
| dac_code_b | output | 12 | Output code, channel B |
| dac_code_c | output | 12 | Output code, channel C |
| dac_code_d | output | 12 | Output code, channel D |
| dac_load | output | 1 | One-cycle pulse when any output code is loaded |

## Verification
A directed sequence follows the intended software pattern: set control to 1, write all four channels, then clear control. It checks that the outputs do not move until the clear, and then that all four change together with a single strobe. Separate directed writes cover unchanged control values, transparent mode, undecoded addresses, a strobe without chip select, and data with the upper four bits set. These cases separate a correct design from one that leaks holding values early, loses the upper-bit masking, or decodes neighbouring addresses. A random stream then mixes channel, control and undecoded writes, dropped chip selects and random reads, and compares every output code, the strobe count and the read data against a bench model. This catches ordering faults that only show up when the control state changes between writes.

// File: rtl/dacreg_pkg.sv
package dacreg_pkg;

    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 16;
    localparam int CODE_W    = 12;
    localparam int NUM_CH    = 4;
    localparam int CH_IDX_W  = $clog2(NUM_CH);
    localparam int CH_STRIDE = 2;

    localparam logic [ADDR_W-1:0] CH_BASE   = 16'h4100;
    localparam logic [ADDR_W-1:0] XFER_ADDR = 16'h47FF;

    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_CHAN = 2'd1,
        TGT_XFER = 2'd2
    } tgt_e;

    typedef struct packed {
        tgt_e                tgt;
        logic [CH_IDX_W-1:0] ch;
    } dec_t;

    // Map a bus word address to the register it selects.
    function automatic dec_t decode_addr(input logic [ADDR_W-1:0] a);
        dec_t d;
        d.tgt = TGT_NONE;
        d.ch  = '0;
        if (a == XFER_ADDR) begin
            d.tgt = TGT_XFER;
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (a == CH_BASE + ADDR_W'(i * CH_STRIDE)) begin
                d.tgt = TGT_CHAN;
                d.ch  = CH_IDX_W'(i);
            end
        end
        return d;
    endfunction

    function automatic logic [DATA_W-1:0] zext_code(input code_t c);
        return {{(DATA_W-CODE_W){1'b0}}, c};
    endfunction

endpackage

// File: rtl/dacreg_sync.sv
module dacreg_sync
    import dacreg_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic wr_n,
    input  logic rd_n,
    output logic cs_act,
    output logic rd_act,
    output logic wr_pulse
);
    localparam int NSIG = 3;

    logic [NSIG-1:0] chain [STAGES];
    logic            wr_prev;
    logic [NSIG-1:0] synced;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '1;
            wr_prev <= 1'b1;
        end else begin
            chain[0] <= {rd_n, wr_n, cs_n};
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
            wr_prev <= chain[STAGES-1][1];
        end
    end

    assign synced   = chain[STAGES-1];
    assign cs_act   = ~synced[0];
    assign rd_act   = ~synced[2];
    assign wr_pulse = synced[1] & ~wr_prev;

    // One capture per strobe edge.
    assert_single_capture_R10: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |=> !wr_pulse);

endmodule

// File: rtl/dacreg_decode.sv
module dacreg_decode
    import dacreg_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    always_comb begin
        dec = decode_addr(addr);
    end
endmodule

// File: rtl/dacreg_bank.sv
module dacreg_bank
    import dacreg_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  dec_t                     dec,
    input  code_t                    wcode,
    input  logic                     wbit0,
    output logic [NUM_CH-1:0][CODE_W-1:0] hold,
    output logic [NUM_CH-1:0][CODE_W-1:0] outs,
    output logic                     ctl,
    output logic                     load
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hold <= '0;
            outs <= '0;
            ctl  <= 1'b0;
            load <= 1'b0;
        end else begin
            load <= 1'b0;
            if (wr_en) begin
                unique case (dec.tgt)
                    TGT_CHAN: begin
                        hold[dec.ch] <= wcode;
                        if (!ctl) begin
                            outs[dec.ch] <= wcode;
                            load         <= 1'b1;
                        end
                    end
                    TGT_XFER: begin
                        ctl <= wbit0;
                        if (ctl && !wbit0) begin
                            outs <= hold;
                            load <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (outs == '0 && hold == '0 && !ctl && !load));

    assert_hold_while_armed_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(ctl) && ctl) |-> $stable(outs));

    assert_commit_all_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl) |-> (load && outs == $past(hold)));

    assert_pulse_width_R6: assert property (@(posedge clk) disable iff (rst)
        load |=> !load);

    assert_change_needs_load_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(outs) |-> load);

endmodule

// File: rtl/quad_dac_regs.sv
module quad_dac_regs
    import dacreg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_cs_n,
    input  logic        bus_wr_n,
    input  logic        bus_rd_n,
    input  logic [15:0] bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic [11:0] dac_code_a,
    output logic [11:0] dac_code_b,
    output logic [11:0] dac_code_c,
    output logic [11:0] dac_code_d,
    output logic        dac_load
);
    logic cs_act, rd_act, wr_pulse;
    dec_t dec;
    logic [NUM_CH-1:0][CODE_W-1:0] hold, outs;
    logic ctl;
    logic [DATA_W-1:0] rd_val;
    logic unused_hi;

    assign unused_hi = ^bus_wdata[DATA_W-1:CODE_W];

    dacreg_sync #(.STAGES(2)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .cs_n    (bus_cs_n),
        .wr_n    (bus_wr_n),
        .rd_n    (bus_rd_n),
        .cs_act  (cs_act),
        .rd_act  (rd_act),
        .wr_pulse(wr_pulse)
    );

    dacreg_decode u_dec (
        .addr(bus_addr),
        .dec (dec)
    );

    dacreg_bank u_bank (
        .clk  (clk),
        .rst  (rst),
        .wr_en(wr_pulse & cs_act),
        .dec  (dec),
        .wcode(bus_wdata[CODE_W-1:0]),
        .wbit0(bus_wdata[0]),
        .hold (hold),
        .outs (outs),
        .ctl  (ctl),
        .load (dac_load)
    );

    always_comb begin
        unique case (dec.tgt)
            TGT_CHAN: rd_val = zext_code(hold[dec.ch]);
            TGT_XFER: rd_val = {{(DATA_W-1){1'b0}}, ctl};
            default:  rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) bus_rdata <= '0;
        else     bus_rdata <= (rd_act && cs_act) ? rd_val : '0;
    end

    assign dac_code_a = outs[0];
    assign dac_code_b = outs[1];
    assign dac_code_c = outs[2];
    assign dac_code_d = outs[3];

    assert_idle_read_zero_R11: assert property (@(posedge clk) disable iff (rst)
        !(rd_act && cs_act) |=> (bus_rdata == '0));

    assert_undecoded_read_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_act && cs_act && dec.tgt == TGT_NONE) |=> (bus_rdata == '0));

    assert_upper_read_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_act && cs_act && dec.tgt == TGT_CHAN) |=> (bus_rdata[15:12] == 4'h0));

endmodule

// File: tb/sim_quad_dac_regs.sv
module sim_quad_dac_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
    logic [15:0] addr = '0, wdata = '0;
    logic [15:0] rdata;
    logic [11:0] qa, qb, qc, qd;
    logic        load;

    int checks = 0, errors = 0, strobes = 0, exp_strobes = 0;
    logic        load_prev = 1'b0;
    logic [11:0] m_hold [4];
    logic [11:0] m_out  [4];
    logic        m_ctl;

    always #4 clk = ~clk;

    quad_dac_regs u0 (
        .clk(clk), .rst(rst), .bus_cs_n(cs_n), .bus_wr_n(wr_n), .bus_rd_n(rd_n),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
        .dac_code_a(qa), .dac_code_b(qb), .dac_code_c(qc), .dac_code_d(qd),
        .dac_load(load)
    );

    always @(negedge clk) begin
        if (load) strobes++;
        if (load && load_prev) begin
            errors++;
            $display("FAIL R6 strobe wider than one cycle: actual 2+ expected 1");
        end
        load_prev = load;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(input logic [15:0] a);
        for (int i = 0; i < 4; i++)
            if (a == 16'h4100 + 16'(2*i)) return {4'h0, m_hold[i]};
        if (a == 16'h47FF) return {15'h0, m_ctl};
        return 16'h0;
    endfunction

    function automatic logic [15:0] pick_addr(input int sel);
        case (sel)
            0, 1, 2, 3: return 16'h4100 + 16'(2*sel);
            4, 5:       return 16'h47FF;
            6:          return 16'h4101 + 16'(2*($urandom % 4));
            default:    return 16'h4108 + 16'($urandom % 16'h6F0);
        endcase
    endfunction

    // Model of one accepted write.
    task automatic model_write(input logic [15:0] a, input logic [15:0] d);
        for (int i = 0; i < 4; i++)
            if (a == 16'h4100 + 16'(2*i)) begin
                m_hold[i] = d[11:0];
                if (!m_ctl) begin m_out[i] = d[11:0]; exp_strobes++; end
            end
        if (a == 16'h47FF) begin
            if (m_ctl && !d[0]) begin
                for (int i = 0; i < 4; i++) m_out[i] = m_hold[i];
                exp_strobes++;
            end
            m_ctl = d[0];
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [15:0] d, input bit sel);
        cs_n = ~sel; addr = a; wdata = d;
        @(negedge clk); wr_n = 1'b0;
        repeat (3) @(negedge clk);
        wr_n = 1'b1;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (2) @(negedge clk);
        if (sel) model_write(a, d);
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [15:0] d);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        repeat (4) @(negedge clk);
        d = rdata;
        rd_n = 1'b1; cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic check_outs(input string req);
        check(req, qa, m_out[0]);
        check(req, qb, m_out[1]);
        check(req, qc, m_out[2]);
        check(req, qd, m_out[3]);
        check(req, strobes, exp_strobes);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] rv;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) begin m_hold[i] = '0; m_out[i] = '0; end
        m_ctl = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R1 reset state
        check_outs("R1");
        check("R1 load", load, 0);
        bus_read(16'h4100, rv); check("R1 read chan", rv, 0);
        bus_read(16'h47FF, rv); check("R1 read ctl", rv, 0);
        check("R11 idle rdata", rdata, 0);

        // R4, R5 armed, then load all four with upper bits set (R3)
        bus_write(16'h47FF, 16'h0001, 1);
        bus_read(16'h47FF, rv); check("R4 ctl read", rv, 16'h0001);
        bus_write(16'h4100, 16'hF123, 1);
        bus_write(16'h4102, 16'hA456, 1);
        bus_write(16'h4104, 16'h5789, 1);
        bus_write(16'h4106, 16'h3FFF, 1);
        check("R5 outputs held", {qa, qb, qc, qd}, 48'h0);
        check("R5 no strobe", strobes, 0);
        bus_read(16'h4100, rv); check("R2 R3 read A", rv, 16'h0123);
        bus_read(16'h4106, rv); check("R2 read D", rv, 16'h0FFF);
        bus_write(16'h47FF, 16'h0001, 1);
        check("R8 1->1 no strobe", strobes, 0);

        // R6 commit on 1->0
        bus_write(16'h47FF, 16'hFFFE, 1);
        check("R6 A", qa, 12'h123);
        check("R6 D", qd, 12'hFFF);
        check("R6 one strobe", strobes, 1);
        bus_write(16'h47FF, 16'h0000, 1);
        check("R8 0->0 no strobe", strobes, 1);

        // R7 transparent write
        bus_write(16'h4102, 16'h0800, 1);
        check("R7 B direct", qb, 12'h800);
        check("R7 strobe", strobes, 2);

        // R9 undecoded write and read
        bus_write(16'h4101, 16'h0555, 1);
        bus_write(16'h4108, 16'h0555, 1);
        check_outs("R9");
        bus_read(16'h4101, rv); check("R9 read", rv, 0);

        // R10 strobe without chip select
        bus_write(16'h4104, 16'h0777, 0);
        check_outs("R10");
        bus_read(16'h4104, rv); check("R10 hold", rv, exp_read(16'h4104));

        // Random mix
        for (int n = 0; n < 300; n++) begin
            logic [15:0] a;
            a = pick_addr($urandom % 9);
            if ($urandom % 4 == 0) begin
                bus_read(a, rv);
                check("R2 R4 R9 random read", rv, exp_read(a));
            end else begin
                bus_write(a, 16'($urandom), ($urandom % 10) != 0);
                check_outs("R5 R6 R7 R10 random");
            end
        end
        check("R11 idle end", rdata, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule